// File: doc/BRIEF.md
# Two-Core Idle Power State Sequencer

This block decides when a two-core package may go idle. It leaves the idle state on wake events. On the way into and out of the deep idle state, it sets the order of the core clock ratio and voltage code changes. Each core raises its halt line once it has stopped. The package idles only when every halt line is high. A single halted core leaves the package running. A shallow idle state (HALT) keeps the normal operating point. When the deep-idle enable is set, the block uses the deep idle state instead. There it lowers the core ratio first and the voltage code second. On wake-up it undoes both changes in the reverse order.

Wake sources are four break lines: a management interrupt, an init request, a non-maskable interrupt and a maskable interrupt. A stop-clock request also acts on the shallow idle state. A management interrupt parks the package in a management state. A return pulse then sends it to either HALT or running, as the return-target input chooses. Each ratio or voltage step lasts a programmable settle count, or ends early when the step-acknowledge input is high. Snoop requests that arrive in an idle state are acknowledged. Only the internal core ratio is driven by this block; the external bus clock is not touched.

Top module: `idle_power_sequencer`

## Requirements
- R1: When `rst_n` is low at a clock edge, the next state is 0 (running), `core_ratio` = `cfg_norm_ratio`, `core_volt` = `cfg_norm_volt` and `snoop_ack` = 0. This holds from any state.
- R2: From running (0), the package leaves at the next edge only when every bit of `halt_req` is 1 and no break line is high. With any partial halt pattern it stays at state 0.
- R3: With all cores halted, `ext_en` = 0 selects HALT (state 1). `ext_en` = 1 selects the ratio-down step (state 4).
- R4: In HALT, `brk_init`, `brk_nmi` or `brk_irq` moves the package to state 0 at the next edge. `brk_mgmt` moves it to the management state (3).
- R5: In the management state, a `mgmt_return` pulse moves the package to HALT (1) when `return_to_halt` = 1, and to running (0) when `return_to_halt` = 0.
- R6: In HALT, `stop_clk` = 1 with no break line high moves the package to the stopped-clock state (2). It stays there while `stop_clk` is high and returns to HALT (1) when `stop_clk` falls. A break line in the same cycle takes priority over `stop_clk`.
- R7: `snoop_ack` is 1 in the cycle after a cycle in which `snoop_req` was high while the state was HALT (1) or deep idle (6). Otherwise it is 0; it is 0 in running, for example.
- R8: Entry order: in state 4, `core_ratio` = `cfg_low_ratio` and `core_volt` = `cfg_norm_volt`. In state 5 (voltage down) and state 6 (deep idle), both outputs carry the low values.
- R9: Exit order: any break line in state 6 moves the package to state 7. State 7 holds `core_volt` = `cfg_norm_volt` with `core_ratio` = `cfg_low_ratio`. It is followed by state 8, which holds both normal values, and then by running (0).
- R10: Each step state (4, 5, 7, 8) lasts `cfg_settle`+1 cycles when `step_ack` is low. It lasts one cycle when `step_ack` is high.
- R11: A break line seen during states 4 or 5 is held. After state 5 ends, the package goes straight to state 7 without visiting state 6.
- R12: If `brk_mgmt` was seen in any of states 4 to 8, the exit sequence ends in the management state (3) instead of running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | NUM_CORES | Per-core halted flag |
| ext_en | input | 1 | Use deep idle instead of HALT |
| brk_mgmt | input | 1 | Management interrupt break |
| brk_init | input | 1 | Init request break |
| brk_nmi | input | 1 | Non-maskable interrupt break |
| brk_irq | input | 1 | Maskable interrupt break |
| stop_clk | input | 1 | Stop-clock request |
| mgmt_return | input | 1 | Return pulse from management handler |
| return_to_halt | input | 1 | Return target: 1 HALT, 0 running |
| snoop_req | input | 1 | Bus snoop request |
| step_ack | input | 1 | Ends the current ratio or voltage step early |
| cfg_norm_ratio | input | RATIO_W | Normal core ratio |
| cfg_low_ratio | input | RATIO_W | Low-power core ratio |
| cfg_norm_volt | input | VOLT_W | Normal voltage code |
| cfg_low_volt | input | VOLT_W | Low-power voltage code |
| cfg_settle | input | SETTLE_W | Extra cycles per step |
| core_ratio | output | RATIO_W | Core clock ratio select |
| core_volt | output | VOLT_W | Voltage code |
| snoop_ack | output | 1 | Snoop acknowledge |
| pkg_state | output | 4 | Current state code (0 to 8) |

## Verification
Every pattern of halt lines is applied with the deep-idle enable both off and on. This separates entry on all cores from entry on a partial halt, and shallow idle from deep idle. Each of the four break lines is applied in HALT, with and without a concurrent stop-clock, to show which wake target each line has and that breaks beat stop-clock. The deep sequence is swept over settle counts 0 to 3 and every break kind, with and without the step acknowledge. Each cycle's ratio and voltage are compared against the counted step lengths. A break injected during entry shows that it is held and that deep idle is skipped.

// File: rtl/idle_seq_pkg.sv
// Shared state encoding and state classification helpers for the idle
// power sequencer. Assumes at most 16 states (4-bit code).
package idle_seq_pkg;

    typedef enum logic [3:0] {
        PS_RUN      = 4'd0,
        PS_HALT     = 4'd1,
        PS_CLKSTOP  = 4'd2,
        PS_MGMT     = 4'd3,
        PS_RATIO_DN = 4'd4,
        PS_VOLT_DN  = 4'd5,
        PS_DEEP     = 4'd6,
        PS_VOLT_UP  = 4'd7,
        PS_RATIO_UP = 4'd8
    } pstate_t;

    // States that wait on the step timer
    function automatic logic is_step(pstate_t s);
        return (s == PS_RATIO_DN) || (s == PS_VOLT_DN) ||
               (s == PS_VOLT_UP)  || (s == PS_RATIO_UP);
    endfunction

    // States that belong to the deep idle excursion
    function automatic logic is_deep_path(pstate_t s);
        return is_step(s) || (s == PS_DEEP);
    endfunction

    // States in which the core runs at the low ratio
    function automatic logic uses_low_ratio(pstate_t s);
        return (s == PS_RATIO_DN) || (s == PS_VOLT_DN) ||
               (s == PS_DEEP)     || (s == PS_VOLT_UP);
    endfunction

    // States in which the voltage code is low
    function automatic logic uses_low_volt(pstate_t s);
        return (s == PS_VOLT_DN) || (s == PS_DEEP);
    endfunction

    // Idle states that answer snoops
    function automatic logic answers_snoop(pstate_t s);
        return (s == PS_HALT) || (s == PS_DEEP);
    endfunction

endpackage

// File: rtl/idle_step_timer.sv
// Step timer: counts cycles since the current ratio/voltage step began and
// reports completion after the settle count, or at once on an acknowledge.
// Assumes cfg_settle is held stable while a step is running.
module idle_step_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                in_step,
    input  logic [SETTLE_W-1:0] settle,
    input  logic                ack,
    output logic                done
);

    logic [SETTLE_W-1:0] cnt_q;

    // Restart on a new step, otherwise count up to the settle limit
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= '0;
        else if (cnt_q < settle) cnt_q <= cnt_q + 1'b1;
    end

    // Step ends once the count is reached or the acknowledge arrives
    always_comb done = in_step && ((cnt_q >= settle) || ack);

    assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && !start && $stable(settle)) |-> (cnt_q <= settle));

endmodule

// File: rtl/idle_state_fsm.sv
// Package idle state machine: decides idle entry from the per-core halt
// flags, handles break events, stop-clock and the management return, and
// sequences the deep idle steps. Breaks seen while entering deep idle are
// held until entry completes. Assumes break lines are level inputs sampled
// on each clock edge.
module idle_state_fsm
    import idle_seq_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] halt_req,
    input  logic                 ext_en,
    input  logic                 brk_mgmt,
    input  logic                 brk_init,
    input  logic                 brk_nmi,
    input  logic                 brk_irq,
    input  logic                 stop_clk,
    input  logic                 mgmt_return,
    input  logic                 return_to_halt,
    input  logic                 step_done,
    output pstate_t              state,
    output logic                 step_start,
    output logic                 in_step
);

    pstate_t nxt;
    logic    wake, any_brk, all_halted;
    logic    brk_pend_q, mgmt_pend_q;

    // Break and halt summaries
    always_comb begin
        wake       = brk_init | brk_nmi | brk_irq;
        any_brk    = wake | brk_mgmt;
        all_halted = &halt_req;
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            PS_RUN:      if (all_halted && !any_brk)
                             nxt = ext_en ? PS_RATIO_DN : PS_HALT;
            PS_HALT:     if (brk_mgmt)      nxt = PS_MGMT;
                         else if (wake)     nxt = PS_RUN;
                         else if (stop_clk) nxt = PS_CLKSTOP;
            PS_CLKSTOP:  if (!stop_clk)     nxt = PS_HALT;
            PS_MGMT:     if (mgmt_return)
                             nxt = return_to_halt ? PS_HALT : PS_RUN;
            PS_RATIO_DN: if (step_done)     nxt = PS_VOLT_DN;
            PS_VOLT_DN:  if (step_done)
                             nxt = (brk_pend_q || any_brk) ? PS_VOLT_UP : PS_DEEP;
            PS_DEEP:     if (any_brk)       nxt = PS_VOLT_UP;
            PS_VOLT_UP:  if (step_done)     nxt = PS_RATIO_UP;
            PS_RATIO_UP: if (step_done)
                             nxt = (mgmt_pend_q || brk_mgmt) ? PS_MGMT : PS_RUN;
            default:     nxt = PS_RUN;
        endcase
    end

    // Step timer control
    always_comb begin
        step_start = is_step(nxt) && (nxt != state);
        in_step    = is_step(state);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_RUN;
        else        state <= nxt;
    end

    // Hold breaks that arrive during deep-idle entry
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_pend_q <= 1'b0;
        else if (state == PS_VOLT_DN && step_done)
            brk_pend_q <= 1'b0;
        else if ((state == PS_RATIO_DN || state == PS_VOLT_DN) && any_brk)
            brk_pend_q <= 1'b1;
    end

    // Remember a management interrupt seen anywhere on the deep path
    always_ff @(posedge clk) begin
        if (!rst_n)
            mgmt_pend_q <= 1'b0;
        else if (state == PS_RATIO_UP && step_done)
            mgmt_pend_q <= 1'b0;
        else if (is_deep_path(state) && brk_mgmt)
            mgmt_pend_q <= 1'b1;
    end

    assert_entry_needs_all_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_RUN && state != PS_RUN) |-> $past(&halt_req));

    assert_volt_dn_after_ratio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_VOLT_DN) |->
            ($past(state) == PS_RATIO_DN || $past(state) == PS_VOLT_DN));

    assert_ratio_up_after_volt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RATIO_UP) |->
            ($past(state) == PS_VOLT_UP || $past(state) == PS_RATIO_UP));

    assert_deep_skipped_on_held_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DEEP && $past(state) != PS_DEEP) |->
            ($past(state) == PS_VOLT_DN && !$past(brk_pend_q)));

    assert_clkstop_only_from_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_CLKSTOP && $past(state) != PS_CLKSTOP) |-> ($past(state) == PS_HALT));

endmodule

// File: rtl/idle_vf_select.sv
// Operating point and snoop stage: picks the core ratio and voltage code
// for the current state and registers the snoop acknowledge. Assumes the
// configuration inputs are static while the package is idle.
module idle_vf_select
    import idle_seq_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int VOLT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pstate_t            state,
    input  logic               snoop_req,
    input  logic [RATIO_W-1:0] cfg_norm_ratio,
    input  logic [RATIO_W-1:0] cfg_low_ratio,
    input  logic [VOLT_W-1:0]  cfg_norm_volt,
    input  logic [VOLT_W-1:0]  cfg_low_volt,
    output logic [RATIO_W-1:0] core_ratio,
    output logic [VOLT_W-1:0]  core_volt,
    output logic               snoop_ack
);

    // Operating point for the current state
    always_comb begin
        core_ratio = uses_low_ratio(state) ? cfg_low_ratio : cfg_norm_ratio;
        core_volt  = uses_low_volt(state)  ? cfg_low_volt  : cfg_norm_volt;
    end

    // Acknowledge snoops that arrive in an idle state
    always_ff @(posedge clk) begin
        if (!rst_n) snoop_ack <= 1'b0;
        else        snoop_ack <= snoop_req && answers_snoop(state);
    end

    assert_low_volt_needs_low_ratio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_low_volt != cfg_norm_volt && core_volt == cfg_low_volt) |->
            (core_ratio == cfg_low_ratio));

    assert_snoop_ack_only_when_asked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_ack |-> $past(snoop_req));

endmodule

// File: rtl/idle_power_sequencer.sv
// Top of the two-core idle power sequencer: joins the state machine, the
// step timer and the operating-point stage. Assumes all inputs are
// synchronous to clk.
module idle_power_sequencer
    import idle_seq_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int RATIO_W   = 6,
    parameter int VOLT_W    = 8,
    parameter int SETTLE_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] halt_req,
    input  logic                 ext_en,
    input  logic                 brk_mgmt,
    input  logic                 brk_init,
    input  logic                 brk_nmi,
    input  logic                 brk_irq,
    input  logic                 stop_clk,
    input  logic                 mgmt_return,
    input  logic                 return_to_halt,
    input  logic                 snoop_req,
    input  logic                 step_ack,
    input  logic [RATIO_W-1:0]   cfg_norm_ratio,
    input  logic [RATIO_W-1:0]   cfg_low_ratio,
    input  logic [VOLT_W-1:0]    cfg_norm_volt,
    input  logic [VOLT_W-1:0]    cfg_low_volt,
    input  logic [SETTLE_W-1:0]  cfg_settle,
    output logic [RATIO_W-1:0]   core_ratio,
    output logic [VOLT_W-1:0]    core_volt,
    output logic                 snoop_ack,
    output logic [3:0]           pkg_state
);

    pstate_t state;
    logic    step_start, in_step, step_done;

    idle_state_fsm #(.NUM_CORES(NUM_CORES)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .halt_req       (halt_req),
        .ext_en         (ext_en),
        .brk_mgmt       (brk_mgmt),
        .brk_init       (brk_init),
        .brk_nmi        (brk_nmi),
        .brk_irq        (brk_irq),
        .stop_clk       (stop_clk),
        .mgmt_return    (mgmt_return),
        .return_to_halt (return_to_halt),
        .step_done      (step_done),
        .state          (state),
        .step_start     (step_start),
        .in_step        (in_step)
    );

    idle_step_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (step_start),
        .in_step (in_step),
        .settle  (cfg_settle),
        .ack     (step_ack),
        .done    (step_done)
    );

    idle_vf_select #(.RATIO_W(RATIO_W), .VOLT_W(VOLT_W)) u_vf (
        .clk            (clk),
        .rst_n          (rst_n),
        .state          (state),
        .snoop_req      (snoop_req),
        .cfg_norm_ratio (cfg_norm_ratio),
        .cfg_low_ratio  (cfg_low_ratio),
        .cfg_norm_volt  (cfg_norm_volt),
        .cfg_low_volt   (cfg_low_volt),
        .core_ratio     (core_ratio),
        .core_volt      (core_volt),
        .snoop_ack      (snoop_ack)
    );

    // Expose the state code
    always_comb pkg_state = state;

endmodule

// File: tb/test_idle_power_sequencer.sv
// Self-checking bench: sweeps halt patterns, break kinds, settle counts and
// the step acknowledge; expected codes and step lengths come from the
// requirements.
module test_idle_power_sequencer;

    localparam int NR = 12, LR = 5, NV = 90, LV = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] halt_req = '0;
    logic       ext_en = 0, brk_mgmt = 0, brk_init = 0, brk_nmi = 0, brk_irq = 0;
    logic       stop_clk = 0, mgmt_return = 0, return_to_halt = 0;
    logic       snoop_req = 0, step_ack = 0;
    logic [5:0] cfg_norm_ratio = 6'(NR), cfg_low_ratio = 6'(LR);
    logic [7:0] cfg_norm_volt = 8'(NV), cfg_low_volt = 8'(LV);
    logic [7:0] cfg_settle = '0;
    logic [5:0] core_ratio;
    logic [7:0] core_volt;
    logic       snoop_ack;
    logic [3:0] pkg_state;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    idle_power_sequencer i_idle_power_sequencer (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .ext_en(ext_en),
        .brk_mgmt(brk_mgmt), .brk_init(brk_init), .brk_nmi(brk_nmi), .brk_irq(brk_irq),
        .stop_clk(stop_clk), .mgmt_return(mgmt_return), .return_to_halt(return_to_halt),
        .snoop_req(snoop_req), .step_ack(step_ack),
        .cfg_norm_ratio(cfg_norm_ratio), .cfg_low_ratio(cfg_low_ratio),
        .cfg_norm_volt(cfg_norm_volt), .cfg_low_volt(cfg_low_volt),
        .cfg_settle(cfg_settle), .core_ratio(core_ratio), .core_volt(core_volt),
        .snoop_ack(snoop_ack), .pkg_state(pkg_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // kind: 0 management, 1 init, 2 nmi, 3 maskable irq
    task automatic set_brk(input int kind, input logic v);
        brk_mgmt = (kind == 0) ? v : 1'b0;
        brk_init = (kind == 1) ? v : 1'b0;
        brk_nmi  = (kind == 2) ? v : 1'b0;
        brk_irq  = (kind == 3) ? v : 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 0;
        halt_req = '0; ext_en = 0; set_brk(0, 0); stop_clk = 0;
        mgmt_return = 0; snoop_req = 0; step_ack = 0;
        tick;
        chk(pkg_state == 0, "R1 state", pkg_state, 0);
        chk(core_ratio == 6'(NR), "R1 ratio", core_ratio, NR);
        chk(core_volt == 8'(NV), "R1 volt", core_volt, NV);
        chk(snoop_ack == 0, "R1 snoop_ack", snoop_ack, 0);
        rst_n = 1;
    endtask

    // Expect state code for len cycles with the given operating point
    task automatic walk(input int code, input int len, input bit lo_r, input bit lo_v, input string req);
        for (int i = 0; i < len; i++) begin
            chk(pkg_state == 4'(code), {req, " state"}, pkg_state, code);
            chk(core_ratio == 6'(lo_r ? LR : NR), {req, " ratio"}, core_ratio, lo_r ? LR : NR);
            chk(core_volt == 8'(lo_v ? LV : NV), {req, " volt"}, core_volt, lo_v ? LV : NV);
            tick;
        end
    endtask

    // Deep idle excursion; early = break during entry
    task automatic run_ext(input int settle, input int kind, input bit ack, input bit early);
        int len;
        do_reset;
        cfg_settle = 8'(settle);
        step_ack = ack;
        len = ack ? 1 : settle + 1;
        ext_en = 1; halt_req = '1;
        tick;
        halt_req = '0;
        chk(pkg_state == 4, "R3 deep entry", pkg_state, 4);
        if (early) begin
            set_brk(kind, 1);
            walk(4, 1, 1, 0, "R8 R10 ratio down");
            set_brk(kind, 0);
            walk(4, len - 1, 1, 0, "R8 R10 ratio down");
            walk(5, len, 1, 1, "R8 R10 volt down");
            walk(7, len, 1, 0, "R11 volt up");
        end else begin
            walk(4, len, 1, 0, "R8 R10 ratio down");
            walk(5, len, 1, 1, "R8 R10 volt down");
            walk(6, 3, 1, 1, "R8 deep idle");
            if (kind == 1) begin
                snoop_req = 1; tick; snoop_req = 0;
                chk(snoop_ack == 1, "R7 ack deep", snoop_ack, 1);
                tick;
                chk(snoop_ack == 0, "R7 ack drop", snoop_ack, 0);
            end
            set_brk(kind, 1);
            tick;
            set_brk(kind, 0);
            walk(7, len, 1, 0, "R9 R10 volt up");
        end
        walk(8, len, 0, 0, "R9 R10 ratio up");
        chk(pkg_state == 4'((kind == 0) ? 3 : 0), "R9 R12 exit target",
            pkg_state, (kind == 0) ? 3 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset;

        // R2 R3: every halt pattern with both enable values
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 4; p++) begin
                do_reset;
                ext_en = e[0]; halt_req = 2'(p);
                tick;
                chk(pkg_state == 4'((p == 3) ? ((e == 1) ? 4 : 1) : 0), "R2 R3 entry",
                    pkg_state, (p == 3) ? ((e == 1) ? 4 : 1) : 0);
            end
        end
        // R2: a break blocks entry
        do_reset;
        halt_req = '1; brk_irq = 1;
        tick;
        chk(pkg_state == 0, "R2 break blocks entry", pkg_state, 0);

        // R4 R5 R6 R7: breaks in HALT, with and without stop-clock
        for (int k = 0; k < 4; k++) begin
            for (int sc = 0; sc < 2; sc++) begin
                do_reset;
                snoop_req = 1;
                tick;
                chk(snoop_ack == 0, "R7 no ack running", snoop_ack, 0);
                snoop_req = 0;
                halt_req = '1;
                tick;
                halt_req = '0;
                chk(pkg_state == 1, "R3 halt", pkg_state, 1);
                snoop_req = 1; tick; snoop_req = 0;
                chk(snoop_ack == 1, "R7 ack halt", snoop_ack, 1);
                set_brk(k, 1); stop_clk = sc[0];
                tick;
                set_brk(k, 0); stop_clk = 0;
                chk(pkg_state == 4'((k == 0) ? 3 : 0), "R4 R6 break target",
                    pkg_state, (k == 0) ? 3 : 0);
                if (k == 0) begin
                    return_to_halt = sc[0];
                    tick;
                    chk(pkg_state == 3, "R5 waits for return", pkg_state, 3);
                    mgmt_return = 1;
                    tick;
                    mgmt_return = 0;
                    chk(pkg_state == 4'((sc == 1) ? 1 : 0), "R5 return target",
                        pkg_state, (sc == 1) ? 1 : 0);
                end
            end
        end

        // R6: stop-clock round trip
        do_reset;
        halt_req = '1; tick; halt_req = '0;
        stop_clk = 1;
        tick;
        chk(pkg_state == 2, "R6 stopped", pkg_state, 2);
        tick;
        chk(pkg_state == 2, "R6 stays stopped", pkg_state, 2);
        stop_clk = 0;
        tick;
        chk(pkg_state == 1, "R6 back to halt", pkg_state, 1);

        // R8 R9 R10 R12: deep idle sweep over settle counts and break kinds
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                run_ext(s, k, 1'b0, 1'b0);
        // R10: acknowledge shortens every step
        for (int k = 0; k < 4; k++)
            run_ext(6, k, 1'b1, 1'b0);
        // R11 R12: break held during entry
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 4; k++)
                run_ext(s, k, 1'b0, 1'b1);

        // R1: reset from deep idle
        do_reset;
        cfg_settle = 0; ext_en = 1; halt_req = '1; tick; halt_req = '0;
        tick; tick;
        chk(pkg_state == 6, "R8 deep reached", pkg_state, 6);
        do_reset;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule